// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block shifts one parallel word per frame onto a single serial output. The clock input is the bit clock itself: every rising edge presents one bit. A frame begins on the first edge where the frame-sync input is sampled high while the engine is free. After a programmable gap of zero, one or two bit clocks, the word follows. While the engine is waiting out that gap or shifting, the output is held at 0, and it is also 0 between frames.

Software places words in a one-deep holding register through a valid/ready pair. It picks the format through a small control interface. A word can be sent raw as 16 bits or as its low byte, MSB first. The low byte can instead be sent LSB first as a forced 8-bit word. A left-justified linear sample can also be compressed to an 8-bit logarithmic code, using either the mu-law or the A-law scheme. Three sticky flags report faults: a reserved delay code, a frame sync that arrives while a word is still in flight, and a frame that starts with no fresh word loaded.

Top module: `fstx_tx`

## Requirements
- R1: While reset is low and at release, `sdo` is 0, `ld_ready` is 1, and `err_cfg`, `err_sync` and `underrun` are 0.
- R2: A frame starts on the first rising edge at which `fs` is 1 and the engine is idle. With an effective delay d (0, 1 or 2), the first data bit is on `sdo` after edge start+d, and each following bit comes one edge later.
- R3: After reset the configuration is delay 0, mode 00 and 16-bit width.
- R4: Writing delay code 3 (binary 11) behaves as a delay of 2 and sets `err_cfg`, which stays set until reset.
- R5: Mode 00 sends MSB first. It sends all 16 bits when `cfg_wide`=1, and only `ld_data[7:0]` as an 8-bit word when `cfg_wide`=0.
- R6: Mode 01 sends `ld_data[7:0]` as an 8-bit word with bit 0 first, whatever the value of `cfg_wide`.
- R7: Mode 10 treats `ld_data[15:2]` as a 14-bit two's-complement sample. The magnitude is clipped to 8159, then 33 is added. If the result is 8192 or more, the code is 0x7F. Otherwise the segment s is the smallest value with result < 64<<s, the mantissa is (result>>(s+1))&15, and the code is {s,mantissa}. The code is then XORed with 0x7F for negative samples and with 0xFF for the rest, and sent as 8 bits MSB first.
- R8: Mode 11 treats `ld_data[15:3]` as a 13-bit two's-complement sample. The magnitude m is the sample for non-negative values and -sample-1 for negative ones. The segment s is the smallest value with m < 32<<s. The mantissa is (m>>1)&15 when s<2, and (m>>s)&15 otherwise. The code {s,mantissa} is XORed with 0xD5 for non-negative samples and with 0x55 for negative ones, and sent as 8 bits MSB first.
- R9: `sdo` is 0 during the delay bits and whenever no frame is active.
- R10: An `fs` sampled high during a frame's delay or shifting, other than on its last bit, leaves the frame unchanged and sets `err_sync`, which stays set until reset.
- R11: An `fs` sampled high while the last bit of a word is on `sdo` starts the next frame at once, so the two words can run without a gap.
- R12: The word is taken from the holding register at frame start. If no word was loaded since the previous frame start, the previous word is sent again (0 if none was ever loaded) and `underrun` is set and stays set until reset.
- R13: `ld_ready` is 1 exactly when the holding register is empty. A load takes place when `ld_valid` and `ld_ready` are both 1 at an edge, and `ld_ready` is 0 after that edge until a frame start takes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fs | input | 1 | Frame-sync input, sampled on rising edges |
| ld_valid | input | 1 | Word offered to the holding register |
| ld_data | input | 16 | Word or left-justified sample to send |
| ld_ready | output | 1 | Holding register empty |
| cfg_wr | input | 1 | Write strobe for the control fields |
| cfg_dly | input | 2 | Data delay code; 3 is reserved |
| cfg_mode | input | 2 | 00 raw MSB first, 01 byte LSB first, 10 mu-law, 11 A-law |
| cfg_wide | input | 1 | Raw mode width: 1 for 16 bits, 0 for 8 bits |
| sdo | output | 1 | Serial data output |
| err_cfg | output | 1 | Sticky reserved delay code flag |
| err_sync | output | 1 | Sticky unexpected frame-sync flag |
| underrun | output | 1 | Sticky missing-word flag |

## Verification
Some rules hold on every cycle, and the assertions check those. The output stays quiet when no frame is active. A frame only starts on a sampled sync. The reserved delay code raises its flag. A stray sync sets the error flag, a start with an empty holding register sets underrun, and every sticky flag stays set. A load drops ready. Other behaviour can only be shown by the bench's scenarios. These are the exact bit order and timing of each format and delay, the companded codes for chosen samples, the retransmitted word after an underrun, the gap-free joining of back-to-back frames, and the fact that a stray sync leaves the word in flight intact.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int DLY_W  = 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int MU_W   = 14;
  localparam int AL_W   = 13;

  typedef enum logic [1:0] {
    MODE_RAW   = 2'b00,
    MODE_LSB8  = 2'b01,
    MODE_MULAW = 2'b10,
    MODE_ALAW  = 2'b11
  } fmt_mode_e;

  typedef struct packed {
    logic [DLY_W-1:0] dly;
    fmt_mode_e        mode;
    logic             wide;
  } cfg_t;

  // Reverse the bit order of one byte.
  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  // Logarithmic compression of a 14-bit linear sample (R7).
  function automatic logic [BYTE_W-1:0] mu_encode(input logic [MU_W-1:0] s);
    logic              sgn;
    logic [MU_W:0]     ext;
    logic [MU_W:0]     mag;
    logic [2:0]        seg;
    logic [3:0]        mant;
    logic [BYTE_W-1:0] code;
    sgn = s[MU_W-1];
    ext = {s[MU_W-1], s};
    mag = sgn ? (~ext + 15'd1) : ext;
    if (mag > 15'd8159) mag = 15'd8159;
    mag = mag + 15'd33;
    seg = 3'd0;
    for (int i = 6; i <= 12; i++) begin
      if (mag[i]) seg = 3'(i - 5);
    end
    mant = 4'(mag >> (int'(seg) + 1));
    if (mag[13]) code = 8'h7F;
    else         code = {1'b0, seg, mant};
    return sgn ? (code ^ 8'h7F) : (code ^ 8'hFF);
  endfunction

  // Logarithmic compression of a 13-bit linear sample (R8).
  function automatic logic [BYTE_W-1:0] alaw_encode(input logic [AL_W-1:0] s);
    logic              sgn;
    logic [AL_W-2:0]   mag;
    logic [2:0]        seg;
    logic [3:0]        mant;
    sgn = s[AL_W-1];
    mag = sgn ? ~s[AL_W-2:0] : s[AL_W-2:0];
    seg = 3'd0;
    for (int i = 5; i <= 11; i++) begin
      if (mag[i]) seg = 3'(i - 4);
    end
    if (seg < 3'd2) mant = mag[4:1];
    else            mant = 4'(mag >> seg);
    return {1'b0, seg, mant} ^ (sgn ? 8'h55 : 8'hD5);
  endfunction

  // Left-aligned word to shift out, MSB of the result goes first.
  function automatic logic [DATA_W-1:0] format_word(input logic [DATA_W-1:0] d,
                                                    input fmt_mode_e m,
                                                    input logic wide);
    logic [BYTE_W-1:0] b;
    case (m)
      MODE_LSB8:  b = rev_byte(d[BYTE_W-1:0]);
      MODE_MULAW: b = mu_encode(d[DATA_W-1 -: MU_W]);
      MODE_ALAW:  b = alaw_encode(d[DATA_W-1 -: AL_W]);
      default:    b = d[BYTE_W-1:0];
    endcase
    if (m == MODE_RAW && wide) return d;
    return {b, {(DATA_W-BYTE_W){1'b0}}};
  endfunction

  function automatic logic [CNT_W-1:0] word_len(input fmt_mode_e m, input logic wide);
    return (m == MODE_RAW && wide) ? CNT_W'(DATA_W) : CNT_W'(BYTE_W);
  endfunction

endpackage

// File: rtl/fstx_cfg.sv
module fstx_cfg import fstx_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DLY_W-1:0] cfg_dly,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_wide,
  output cfg_t             cfg,
  output logic             err_cfg
);

  localparam logic [DLY_W-1:0] DLY_RSV = '1;
  localparam logic [DLY_W-1:0] DLY_MAX = DLY_W'(2);

  cfg_t cfg_q;
  logic err_q;
  logic bad_dly;

  assign bad_dly = cfg_dly == DLY_RSV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.dly  <= '0;
      cfg_q.mode <= MODE_RAW;
      cfg_q.wide <= 1'b1;
      err_q      <= 1'b0;
    end else if (cfg_wr) begin
      cfg_q.dly  <= bad_dly ? DLY_MAX : cfg_dly;
      cfg_q.mode <= fmt_mode_e'(cfg_mode);
      cfg_q.wide <= cfg_wide;
      if (bad_dly) err_q <= 1'b1;
    end
  end

  assign cfg     = cfg_q;
  assign err_cfg = err_q;

endmodule

// File: rtl/fstx_hold.sv
module fstx_hold import fstx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  input  logic              take,
  output logic [DATA_W-1:0] word_out,
  output logic              underrun
);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] prev_q;
  logic              full_q;
  logic              under_q;
  logic              accept;

  assign accept   = ld_valid && !full_q;
  assign word_out = full_q ? hold_q : prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      prev_q  <= '0;
      full_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      if (take) begin
        prev_q <= word_out;
        if (!full_q) under_q <= 1'b1;
      end
      if (accept) begin
        hold_q <= ld_data;
        full_q <= 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end

  assign ld_ready = !full_q;
  assign underrun = under_q;

endmodule

// File: rtl/fstx_shift.sv
module fstx_shift import fstx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  input  cfg_t              cfg,
  input  logic [DATA_W-1:0] word_raw,
  output logic              sdo,
  output logic              frame_start,
  output logic              busy,
  output logic              last_bit,
  output logic              err_sync
);

  logic [DATA_W-1:0] sh_q;
  logic [DLY_W-1:0]  dly_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              sdo_q;
  logic              serr_q;
  logic [DATA_W-1:0] fmt_w;
  logic [CNT_W-1:0]  len_w;
  logic              stray_fs;

  assign fmt_w       = format_word(word_raw, cfg.mode, cfg.wide);
  assign len_w       = word_len(cfg.mode, cfg.wide);
  assign last_bit    = busy_q && (dly_q == '0) && (cnt_q == CNT_W'(1));
  assign frame_start = fs && (!busy_q || last_bit);
  assign stray_fs    = fs && busy_q && !last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      dly_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sdo_q  <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      if (stray_fs) serr_q <= 1'b1;
      if (frame_start) begin
        busy_q <= 1'b1;
        cnt_q  <= len_w;
        dly_q  <= cfg.dly;
        if (cfg.dly == '0) begin
          sdo_q <= fmt_w[DATA_W-1];
          sh_q  <= fmt_w << 1;
        end else begin
          sdo_q <= 1'b0;
          sh_q  <= fmt_w;
        end
      end else if (last_bit) begin
        busy_q <= 1'b0;
        sdo_q  <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (dly_q != '0) begin
          dly_q <= dly_q - DLY_W'(1);
          if (dly_q == DLY_W'(1)) begin
            sdo_q <= sh_q[DATA_W-1];
            sh_q  <= sh_q << 1;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
          sdo_q <= sh_q[DATA_W-1];
          sh_q  <= sh_q << 1;
        end
      end
    end
  end

  assign sdo      = sdo_q;
  assign busy     = busy_q;
  assign err_sync = serr_q;

endmodule

// File: rtl/fstx_tx.sv
module fstx_tx import fstx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  input  logic              cfg_wr,
  input  logic [DLY_W-1:0]  cfg_dly,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_wide,
  output logic              sdo,
  output logic              err_cfg,
  output logic              err_sync,
  output logic              underrun
);

  cfg_t              cfg;
  logic [DATA_W-1:0] word_raw;
  logic              frame_start;
  logic              busy;
  logic              last_bit;

  fstx_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_dly  (cfg_dly),
    .cfg_mode (cfg_mode),
    .cfg_wide (cfg_wide),
    .cfg      (cfg),
    .err_cfg  (err_cfg)
  );

  fstx_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_data  (ld_data),
    .ld_ready (ld_ready),
    .take     (frame_start),
    .word_out (word_raw),
    .underrun (underrun)
  );

  fstx_shift u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs          (fs),
    .cfg         (cfg),
    .word_raw    (word_raw),
    .sdo         (sdo),
    .frame_start (frame_start),
    .busy        (busy),
    .last_bit    (last_bit),
    .err_sync    (err_sync)
  );

endmodule

// File: rtl/fstx_tx_chk.sv
module fstx_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fs,
  input logic       ld_valid,
  input logic       ld_ready,
  input logic       cfg_wr,
  input logic [1:0] cfg_dly,
  input logic       sdo,
  input logic       err_cfg,
  input logic       err_sync,
  input logic       underrun,
  input logic       frame_start,
  input logic       busy,
  input logic       last_bit
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo); // R9

  AST_START_NEEDS_FS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> fs); // R2

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> busy); // R2

  AST_BAD_DLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_dly == 2'b11) |=> err_cfg); // R4

  AST_CFG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_cfg |=> err_cfg); // R4

  AST_STRAY_SYNC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fs && busy && !last_bit) |=> err_sync); // R10

  AST_SYNC_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_sync |=> err_sync); // R10

  AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && ld_ready) |=> underrun); // R12

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun); // R12

  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !ld_ready); // R13

endmodule

bind fstx_tx fstx_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fs          (fs),
  .ld_valid    (ld_valid),
  .ld_ready    (ld_ready),
  .cfg_wr      (cfg_wr),
  .cfg_dly     (cfg_dly),
  .sdo         (sdo),
  .err_cfg     (err_cfg),
  .err_sync    (err_sync),
  .underrun    (underrun),
  .frame_start (frame_start),
  .busy        (busy),
  .last_bit    (last_bit)
);

// File: tb/tb_fstx_tx.sv
module tb_fstx_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_data = '0;
  logic        ld_ready;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_dly = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_wide = 1'b0;
  logic        sdo;
  logic        err_cfg;
  logic        err_sync;
  logic        underrun;

  int total = 0;
  int bad = 0;

  bit    exp_q[$];
  string tag_q[$];

  // bench model of configuration and holding register
  int          m_dly = 0;
  int          m_mode = 0;
  bit          m_wide = 1'b1;
  bit          m_pend_v = 1'b0;
  logic [15:0] m_pend = '0;
  logic [15:0] m_last = '0;
  bit          m_under = 1'b0;

  always #2 clk = ~clk;

  fstx_tx dut (
    .clk(clk), .rst_n(rst_n), .fs(fs), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_ready(ld_ready), .cfg_wr(cfg_wr), .cfg_dly(cfg_dly), .cfg_mode(cfg_mode),
    .cfg_wide(cfg_wide), .sdo(sdo), .err_cfg(err_cfg), .err_sync(err_sync),
    .underrun(underrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_mu(input logic [15:0] w);
    int s, m, seg, code;
    bit neg;
    s = int'($signed(w)) >>> 2;
    neg = s < 0;
    m = neg ? -s : s;
    if (m > 8159) m = 8159;
    m = m + 33;
    if (m >= 8192) code = 127;
    else begin
      seg = 0;
      while (m >= (64 << seg)) seg++;
      code = (seg << 4) | ((m >> (seg + 1)) & 15);
    end
    return neg ? (code ^ 127) : (code ^ 255);
  endfunction

  function automatic int ref_alaw(input logic [15:0] w);
    int s, m, seg, mant, mask;
    s = int'($signed(w)) >>> 3;
    if (s >= 0) begin mask = 213; m = s; end
    else begin mask = 85; m = -s - 1; end
    seg = 0;
    while (m >= (32 << seg)) seg++;
    mant = (seg < 2) ? ((m >> 1) & 15) : ((m >> seg) & 15);
    return ((seg << 4) | mant) ^ mask;
  endfunction

  // Scoreboard driver side: compute the expected serial stream of one frame.
  task automatic push_frame(input string tag, output int t);
    logic [15:0] w;
    int code;
    w = m_pend_v ? m_pend : m_last;
    if (!m_pend_v) m_under = 1'b1;
    m_last = w;
    m_pend_v = 1'b0;
    for (int i = 0; i < m_dly; i++) begin exp_q.push_back(1'b0); tag_q.push_back("R9 delay bit low"); end
    if (m_mode == 0 && m_wide) begin
      for (int i = 15; i >= 0; i--) begin exp_q.push_back(w[i]); tag_q.push_back(tag); end
      t = m_dly + 16;
    end else begin
      case (m_mode)
        1: code = 0;
        2: code = ref_mu(w);
        3: code = ref_alaw(w);
        default: code = int'(w[7:0]);
      endcase
      for (int i = 0; i < 8; i++) begin
        exp_q.push_back(m_mode == 1 ? w[i] : code[7-i]);
        tag_q.push_back(tag);
      end
      t = m_dly + 8;
    end
  endtask

  // All driver tasks start and end just after a falling edge.
  task automatic do_cfg(input int d, input int mode, input bit wide);
    cfg_wr = 1'b1; cfg_dly = 2'(d); cfg_mode = 2'(mode); cfg_wide = wide;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_dly = (d == 3) ? 2 : d;
    m_mode = mode;
    m_wide = wide;
  endtask

  task automatic do_load(input logic [15:0] v);
    check("R13 ready before load", ld_ready, 1);
    ld_valid = 1'b1; ld_data = v;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R13 ready low after load", ld_ready, 0);
    m_pend = v;
    m_pend_v = 1'b1;
  endtask

  task automatic frame(input string tag, input int gap);
    int t;
    fs = 1'b1;
    push_frame(tag, t);
    @(negedge clk);
    fs = 1'b0;
    repeat (t - 1 + gap) @(negedge clk);
    check("R12 underrun flag", underrun, m_under);
  endtask

  task automatic frame_with_stray(input string tag);
    int t;
    fs = 1'b1;
    push_frame(tag, t);
    @(negedge clk);
    fs = 1'b0;
    repeat (3) @(negedge clk);
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
    repeat (t - 3) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Scoreboard monitor side
  initial begin
    bit e;
    string tg;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, sdo, e);
      end else begin
        check("R9 idle output low", sdo, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sdo in reset", sdo, 0);
    check("R1 ready in reset", ld_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", {err_cfg, err_sync, underrun}, 0);
    check("R1 ready after reset", ld_ready, 1);

    // R3: default configuration, no write
    do_load(16'hA5C3);
    frame("R3 default delay0 raw16", 2);

    // R2: delays 1 and 2
    do_cfg(1, 0, 1'b1);
    do_load(16'h3C96);
    frame("R2 delay1 raw16", 2);
    do_cfg(2, 0, 1'b1);
    do_load(16'h8001);
    frame("R2 delay2 raw16", 2);

    // R5: 8-bit raw
    do_cfg(1, 0, 1'b0);
    do_load(16'h12B7);
    frame("R5 raw8 low byte", 2);

    // R6: LSB first, forced 8 bits
    do_cfg(1, 1, 1'b1);
    do_load(16'h00C1);
    frame("R6 lsb first wide set", 2);
    do_cfg(0, 1, 1'b0);
    do_load(16'hFF2D);
    frame("R6 lsb first", 2);

    // R7: mu-law
    do_cfg(1, 2, 1'b0);
    foreach (mu_smp[i]) begin
      do_load(mu_smp[i]);
      frame("R7 mulaw code", 2);
    end

    // R8: A-law
    do_cfg(2, 3, 1'b1);
    foreach (al_smp[i]) begin
      do_load(al_smp[i]);
      frame("R8 alaw code", 2);
    end

    // R11: back-to-back frames with the second word loaded mid-frame
    do_cfg(0, 0, 1'b0);
    do_load(16'h005A);
    fork
      frame("R11 first of pair", 0);
      begin
        @(negedge clk); @(negedge clk);
        do_load(16'h00E4);
      end
    join
    frame("R11 second of pair", 2);

    // R10: stray sync while shifting
    check("R10 no sync error yet", err_sync, 0);
    do_cfg(1, 0, 1'b1);
    do_load(16'hC3A5);
    frame_with_stray("R10 word intact under stray sync");
    check("R10 sync error flag", err_sync, 1);

    // R12: underrun retransmits previous word
    check("R12 no underrun yet", underrun, 0);
    frame("R12 retransmitted word", 2);
    check("R12 underrun set", underrun, 1);

    // R4: reserved delay code
    check("R4 no config error yet", err_cfg, 0);
    do_cfg(3, 0, 1'b1);
    check("R4 config error flag", err_cfg, 1);
    do_load(16'h6E19);
    frame("R4 reserved code acts as delay2", 2);
    check("R4 config error sticky", err_cfg, 1);

    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  logic [15:0] mu_smp [6] = '{16'h0000, 16'h7FFC, 16'h8000, 16'hFFFC, 16'h1234, 16'hE000};
  logic [15:0] al_smp [6] = '{16'h0000, 16'h7FF8, 16'h8000, 16'hFFF8, 16'h0100, 16'hF318};

endmodule